// File: doc/BRIEF.md
# Reset-Release Strap Capture and Boot Sequencer

This block brings a switch-style device out of its fundamental reset. A set of board strap pins is sampled exactly once, on the first clock after the internally synchronized reset releases. From these pins it builds two 7-bit bus addresses. One is the address the management slave answers to. The other is the address of the configuration EEPROM that the master side reads. Fixed bits are merged with the pins in both cases. It also latches the master-bus slow-speed strap, so software has no way to change it afterwards.

A 3-bit mode strap decides whether an EEPROM configuration load is requested before normal operation begins. The load request is a level that stays high until the external transfer engine answers with a one-cycle done pulse.

A separate halt strap can park the device after the reset procedure. While parked, `halted` is high and `run_en` stays low, and the management buses are expected to remain usable. The device leaves this state only when software clears the halt control bit, which the register file reports to this block as a one-cycle pulse.

Top module: `strap_boot_ctrl`

## Requirements
- R1: Strap values are captured on the third rising clock edge after `rst_n_in` rises, through a two-stage reset synchronizer. Strap pins pass through a two-flop synchronizer first. Changes on any strap pin after capture leave `slv_addr`, `eep_addr`, `bus_slow` and `mode_err` unchanged until the next reset.
- R2: `slv_addr` (bit 0 = LSB) is built as follows:
  - `{1, 1, slv_pins[3], 0, slv_pins[2], slv_pins[1], slv_pins[0]}`, written from bit 6 down to bit 0.
  - Bits 6 and 5 are 1 and bit 3 is 0.
- R3: `eep_addr` is `{1, 0, 1, eep_pins[3:0]}`, written from bit 6 down to bit 0.
- R4: Mode strap 0 requests no load. `run_en` rises on the capture edge when no halt is strapped.
- R5: Mode strap 1 raises `load_req` on the capture edge. `load_req` stays high until the clock edge that samples `load_done` high, and falls on that edge. `run_en` stays low until then.
- R6: Mode straps 2 to 7 set `mode_err`, which stays set until reset. No load is requested, and the device otherwise behaves as in mode 0.
- R7: If the halt strap is 1 at capture, `halted` rises once the reset procedure completes. That point is the capture edge, or the done edge when a load was requested. `halted` holds and `run_en` stays low until the edge that samples `halt_clear` high. On that edge `halted` falls and `run_en` rises.
- R8: `load_done` has no effect outside a pending load, and `halt_clear` has no effect when no halt is pending.
- R9: `bus_slow` equals the slow-mode strap sampled at capture.
- R10: While `rst_n_in` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n_in | input | 1 | Fundamental reset, active low, asynchronous assert |
| slv_pins | input | 4 | Slave address straps for address bits 0,1,2,4 |
| eep_pins | input | 4 | EEPROM address straps for address bits 0..3 |
| mode_pins | input | 3 | Boot mode strap |
| halt_pin | input | 1 | Reset-halt strap |
| slow_pin | input | 1 | Master bus slow-speed strap |
| load_done | input | 1 | One-cycle completion pulse from the EEPROM transfer engine |
| halt_clear | input | 1 | One-cycle pulse: software cleared the halt bit |
| slv_addr | output | 7 | Captured management slave address |
| eep_addr | output | 7 | Captured configuration EEPROM address |
| bus_slow | output | 1 | Captured slow-speed selection for the master bus |
| mode_err | output | 1 | Sticky flag for a reserved mode strap |
| load_req | output | 1 | EEPROM configuration load request |
| halted | output | 1 | Device held in halted reset state |
| run_en | output | 1 | Device core run enable |

## Verification
The block has no parameters, so the bench builds its single fixed variant. It runs many reset cycles with random strap words, covering every mode value, including all six reserved ones, and both halt settings. Load completion arrives after random delays. Spurious `load_done` and `halt_clear` pulses are sent where they must be ignored. Strap pins are rerandomized after capture and checked again.

// File: rtl/strap_boot_ctrl.sv
module strap_boot_ctrl (
  input  logic       clk,
  input  logic       rst_n_in,
  input  logic [3:0] slv_pins,
  input  logic [3:0] eep_pins,
  input  logic [2:0] mode_pins,
  input  logic       halt_pin,
  input  logic       slow_pin,
  input  logic       load_done,
  input  logic       halt_clear,
  output logic [6:0] slv_addr,
  output logic [6:0] eep_addr,
  output logic       bus_slow,
  output logic       mode_err,
  output logic       load_req,
  output logic       halted,
  output logic       run_en
);

  typedef enum logic [1:0] {S_RESET, S_LOAD, S_HOLD, S_RUN} phase_t;

  localparam int STRAP_W = 13;

  logic [1:0]         rst_sync;
  logic               core_rst_n;
  logic [STRAP_W-1:0] strap_s1, strap_s2;
  phase_t             phase;
  logic               halt_bit;

  assign core_rst_n = rst_sync[1];

  always_ff @(posedge clk or negedge rst_n_in)
    if (!rst_n_in) rst_sync <= 2'b00;
    else           rst_sync <= {rst_sync[0], 1'b1};

  always_ff @(posedge clk) begin
    strap_s1 <= {slow_pin, halt_pin, mode_pins, eep_pins, slv_pins};
    strap_s2 <= strap_s1;
  end

  wire [3:0] s_slv  = strap_s2[3:0];
  wire [3:0] s_eep  = strap_s2[7:4];
  wire [2:0] s_mode = strap_s2[10:8];
  wire       s_halt = strap_s2[11];
  wire       s_slow = strap_s2[12];
  wire       capture = (phase == S_RESET) && core_rst_n;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      phase    <= S_RESET;
      slv_addr <= '0;
      eep_addr <= '0;
      bus_slow <= 1'b0;
      mode_err <= 1'b0;
      halt_bit <= 1'b0;
    end else if (capture) begin
      slv_addr <= {2'b11, s_slv[3], 1'b0, s_slv[2:0]};
      eep_addr <= {3'b101, s_eep};
      bus_slow <= s_slow;
      mode_err <= (s_mode > 3'd1);
      halt_bit <= s_halt;
      if (s_mode == 3'd1) phase <= S_LOAD;
      else if (s_halt)    phase <= S_HOLD;
      else                phase <= S_RUN;
    end else begin
      if (halt_clear) halt_bit <= 1'b0;
      case (phase)
        S_LOAD: if (load_done) phase <= (halt_bit && !halt_clear) ? S_HOLD : S_RUN;
        S_HOLD: if (halt_clear) phase <= S_RUN;
        default: ;
      endcase
    end
  end

  assign load_req = (phase == S_LOAD);
  assign halted   = (phase == S_HOLD);
  assign run_en   = (phase == S_RUN);

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!core_rst_n)
    (phase != S_RESET && $past(phase) != S_RESET) |-> ($stable(slv_addr) && $stable(eep_addr) && $stable(bus_slow))); // R1
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!core_rst_n)
    (load_req && !load_done) |=> load_req); // R5
  AST_NO_LOAD_RESERVED: assert property (@(posedge clk) disable iff (!core_rst_n)
    mode_err |-> !load_req); // R6
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!core_rst_n)
    (halted && !halt_clear) |=> halted); // R7
  AST_RUN_CAUSE: assert property (@(posedge clk) disable iff (!core_rst_n)
    $rose(run_en) |-> ($past(load_done) || $past(halt_clear) || $past(phase) == S_RESET)); // R8
  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!core_rst_n)
    $onehot0({load_req, halted, run_en})); // R4

endmodule

// File: tb/strap_boot_ctrl_bench.sv
module strap_boot_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n_in = 0;
  logic [3:0] slv_pins = 0, eep_pins = 0;
  logic [2:0] mode_pins = 0;
  logic halt_pin = 0, slow_pin = 0, load_done = 0, halt_clear = 0;
  logic [6:0] slv_addr, eep_addr;
  logic bus_slow, mode_err, load_req, halted, run_en;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strap_boot_ctrl u_strap_boot_ctrl (.*);

  function automatic logic [6:0] exp_slv(input logic [3:0] p);
    return {1'b1, 1'b1, p[3], 1'b0, p[2], p[1], p[0]};
  endfunction
  function automatic logic [6:0] exp_eep(input logic [3:0] p);
    return {1'b1, 1'b0, 1'b1, p};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic run_case(input logic [3:0] sp, input logic [3:0] ep, input logic [2:0] md,
                          input logic hl, input logic sl, input int dly);
    logic do_load;
    do_load = (md == 3'd1);
    @(negedge clk);
    rst_n_in = 0;
    slv_pins = sp; eep_pins = ep; mode_pins = md; halt_pin = hl; slow_pin = sl;
    load_done = 1; halt_clear = 1;
    repeat (3) tick();
    chk("R10 reset outputs", {slv_addr, eep_addr, bus_slow, mode_err, load_req, halted, run_en}, 0);
    load_done = 0; halt_clear = 0;
    rst_n_in = 1;
    tick(); tick();
    chk("R1 no capture before third edge", {load_req, halted, run_en}, 0);
    tick();
    chk("R2 slave address", slv_addr, exp_slv(sp));
    chk("R3 eeprom address", eep_addr, exp_eep(ep));
    chk("R9 slow strap", bus_slow, sl);
    chk("R6 mode error", mode_err, md > 3'd1);
    chk("R5 load request", load_req, do_load);
    chk("R7 halted at capture", halted, !do_load && hl);
    chk("R4 run at capture", run_en, !do_load && !hl);
    slv_pins = ~sp; eep_pins = ~ep; mode_pins = ~md; slow_pin = ~sl; halt_pin = ~hl;
    if (!hl) halt_clear = 1;
    tick(); halt_clear = 0;
    chk("R1 address hold", {slv_addr, eep_addr, bus_slow, mode_err}, {exp_slv(sp), exp_eep(ep), sl, md > 3'd1});
    chk("R8 stray halt_clear", {load_req, halted, run_en}, {do_load, !do_load && hl, !do_load && !hl});
    if (do_load) begin
      repeat (dly) tick();
      chk("R5 request held", {load_req, run_en}, 2'b10);
      load_done = 1; tick(); load_done = 0;
      chk("R5 request dropped", load_req, 0);
      chk("R7 halt after load", {halted, run_en}, {hl, !hl});
    end else begin
      load_done = 1; tick(); load_done = 0;
      chk("R8 stray load_done", {load_req, halted, run_en}, {1'b0, hl, !hl});
    end
    if (hl) begin
      repeat (dly) tick();
      chk("R7 halt held", {halted, run_en}, 2'b10);
      halt_clear = 1; tick(); halt_clear = 0;
      chk("R7 halt released", {halted, run_en}, 2'b01);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    run_case(4'h0, 4'h0, 3'd0, 0, 0, 0);
    run_case(4'hF, 4'hF, 3'd1, 1, 1, 0);
    run_case(4'hA, 4'h5, 3'd7, 1, 0, 3);
    run_case(4'h5, 4'hA, 3'd2, 0, 1, 1);
    for (int i = 0; i < 300; i++)
      run_case($urandom % 16, $urandom % 16, $urandom % 8, $urandom % 2, $urandom % 2, $urandom % 6);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule